// File: doc/BRIEF.md
# I2C Target Port with Register Handshake

This block lets a small processor answer as a target (slave) on a two-wire I2C bus. It filters the clock and data lines, spots START and STOP conditions, tracks whether the bus is busy, and compares the first seven bits after a START with an own address that software programs. On a match it acknowledges, records the transfer direction, and raises one interrupt line. The same line also fires at the end of each data byte and on a bus time-out. A status register tells these causes apart.

After a match, and after every byte, the port holds SCL low. The bus then waits until the processor touches the data register. When the master reads, the processor writes the byte to send. When the master writes, the processor reads the byte received, or makes a dummy read right after the address. A time-out counter stops a stalled transfer from hanging the bus. When it expires, the port lets go of both lines.

States: IDLE, ADDR (shift in address and direction), ADDR_ACK (drive acknowledge), STRETCH (hold SCL until the data access), RX_BYTE, RX_ACK, TX_BYTE, TX_ACK (sample the master's acknowledge), WAIT_STOP (ignore the bus). Transitions:
- Any state goes to ADDR on START.
- Any state goes to IDLE on STOP, on time-out, or when the port is disabled.
- ADDR goes to ADDR_ACK on a match, or to WAIT_STOP on a mismatch, at the falling clock that ends bit 8.
- ADDR_ACK and RX_ACK go to STRETCH on the next falling clock.
- STRETCH goes to TX_BYTE or RX_BYTE, by the direction bit, once the hold is released.
- RX_BYTE goes to RX_ACK after eight bits.
- TX_BYTE goes to TX_ACK after eight falling clocks.
- TX_ACK goes to STRETCH on an acknowledge, or to WAIT_STOP on a NACK.

Top module: `i2c_target_port`

Register selects (reg_sel):

| Select | Register |
|--------|----------|
| 0 | CTRL: bits [2:0] mode, bit 3 enable, bit 4 interrupt enable |
| 1 | STATUS: bit 0 busy, bit 1 address hit, bit 2 direction, bit 3 time-out, bit 4 interrupt pending, bit 5 master NACK. Bits 5:3 clear when written as 1. |
| 2 | OWN: bits [6:0] own address |
| 3 | DATA: a write loads the byte to send; a read returns the byte received |
| 4 | TOUT: time-out limit in units of 16 clocks; 0 turns the time-out off |

## Requirements
- R1: A falling SDA while SCL is high is a START. Each START sets STATUS bit 0 (busy). After reset every STATUS bit reads 0.
- R2: A rising SDA while SCL is high is a STOP. A STOP clears STATUS bit 0 and bit 1 and returns the port to IDLE.
- R3: The 7 bits after a START arrive MSB first and are compared with OWN[6:0]. A match pulls SDA low during the 9th clock. A mismatch gives no acknowledge, and the port ignores the bus until the next START.
- R4: The 8th bit after a START is stored in STATUS bit 2. A value of 1 means the master reads and the port transmits. A value of 0 means the master writes and the port receives.
- R5: STATUS bit 4 is set by three events: an address match (which also sets bit 1), the end of a data byte, and a time-out (which also sets bit 3). The irq output equals bit 4 AND CTRL bit 4.
- R6: After an address match the port holds SCL low until the processor accesses DATA. When bit 2 is 1 the access is a write. When bit 2 is 0 the access is a read.
- R7: The port works only when CTRL bit 3 is 1 and CTRL[2:0] is 3'b110. A write to OWN while CTRL bit 3 is 1 has no effect.
- R8: With TOUT nonzero, the port counts clocks while SCL is low during an active transfer. When the count reaches TOUT×16, the port sets bit 3, raises bit 4, releases SCL and SDA, and goes to IDLE.
- R9: When transmitting, the DATA byte is sent MSB first. After the master acknowledges, SCL is held low again until the next DATA write.
- R10: A master NACK after a sent byte sets STATUS bit 5. SDA is then released until the next START.
- R11: When receiving, each data byte is acknowledged and becomes readable at DATA. SCL stays low until DATA is read.
- R12: A START in the middle of a transfer (a repeated START) begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on DATA) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest case to reach is the stretch: the master has already released SCL, yet the line must stay low until the processor acts. The bench models an open-drain bus in which a master that honours clock stretching waits on the wired SCL. The processor's DATA access runs in a parallel branch that first samples the bus while the master is blocked. It then performs the access and lets the master continue. A time-out is reached by leaving that access out, and the random part varies the own address, the sent address, the direction and the data.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_STRETCH,
        ST_RX_BYTE, ST_RX_ACK, ST_TX_BYTE, ST_TX_ACK, ST_WAIT_STOP
    } tgt_state_t;

    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_STAT = 3'd1;
    localparam logic [2:0] SEL_OWN  = 3'd2;
    localparam logic [2:0] SEL_DATA = 3'd3;
    localparam logic [2:0] SEL_TOUT = 3'd4;
    localparam logic [2:0] MODE_I2C = 3'b110;

    localparam int ST_BIT_BUSY = 0;
    localparam int ST_BIT_HIT  = 1;
    localparam int ST_BIT_DIR  = 2;
    localparam int ST_BIT_TOUT = 3;
    localparam int ST_BIT_IRQ  = 4;
    localparam int ST_BIT_NAK  = 5;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_END = CW'(FILT_LEN - 1);

    logic [1:0]    meta;
    logic [CW-1:0] cnt;
    logic          line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta   <= 2'b11;
            cnt    <= '0;
            line_q <= 1'b1;
        end else begin
            meta <= {meta[0], pin_i};
            if (meta[1] == line_q) begin
                cnt <= '0;
            end else if (cnt == CNT_END) begin
                line_q <= meta[1];
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign line_o = line_q;
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall,
    output logic busy
);
    logic scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
            busy     <= 1'b0;
        end else begin
            scl_prev <= scl_f;
            sda_prev <= sda_f;
            if (!active)       busy <= 1'b0;
            else if (start_ev) busy <= 1'b1;
            else if (stop_ev)  busy <= 1'b0;
        end
    end

    // SDA edges only count while SCL was high in both samples
    assign start_ev = active && scl_f && scl_prev && sda_prev && !sda_f;
    assign stop_ev  = active && scl_f && scl_prev && !sda_prev && sda_f;
    assign scl_rise = scl_f && !scl_prev;
    assign scl_fall = !scl_f && scl_prev;

    assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> busy);
    assert_idle_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !busy);
endmodule

// File: rtl/i2c_tout_ctr.sv
module i2c_tout_ctr #(
    parameter int LIM_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LIM_W-1:0] limit,
    output logic             expire
);
    localparam int CW = LIM_W + PRE_W;

    logic [CW-1:0] count;
    logic [CW-1:0] target;

    assign target = {limit, {PRE_W{1'b0}}};
    assign expire = run && (limit != '0) && (count == target);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (!run)    count <= '0;
        else if (!expire) count <= count + 1'b1;
    end

    assert_fresh_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !expire);
endmodule

// File: rtl/i2c_target_port.sv
module i2c_target_port
    import i2c_tgt_pkg::*;
#(
    parameter int DW       = 8,
    parameter int FILT_LEN = 3,
    parameter int PRE_W    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    input  logic          scl_i,
    output logic          scl_oe,
    input  logic          sda_i,
    output logic          sda_oe
);
    localparam int AW  = DW - 1;
    localparam int BCW = $clog2(DW + 1);
    localparam logic [BCW-1:0] BIT_FULL = BCW'(DW);
    localparam logic [BCW-1:0] BIT_TXEND = BCW'(DW - 1);

    // line filtering, one instance per wire
    logic [1:0] pins_raw, pins_flt;
    assign pins_raw = {sda_i, scl_i};
    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_line_sync #(.FILT_LEN(FILT_LEN)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin_i(pins_raw[g]), .line_o(pins_flt[g]));
    end
    logic scl_f, sda_f;
    assign scl_f = pins_flt[0];
    assign sda_f = pins_flt[1];

    // registers
    logic [2:0]    ctrl_mode;
    logic          ctrl_en, ctrl_irq_en;
    logic [AW-1:0] own_addr;
    logic [DW-1:0] tout_lim, tx_buf, rx_data, shreg;
    logic [BCW-1:0] bitcnt;
    logic          rw_q, addr_hit, tout_flag, irq_pend, rx_nak, hold_req, ack_sda;
    tgt_state_t    state, st_nx;

    logic active, start_ev, stop_ev, scl_rise, scl_fall, busy, tout_ev, tout_run;
    logic data_wr, data_rd, addr_match;

    assign active     = ctrl_en && (ctrl_mode == MODE_I2C);
    assign data_wr    = reg_wr && (reg_sel == SEL_DATA);
    assign data_rd    = reg_rd && (reg_sel == SEL_DATA);
    assign addr_match = (shreg[DW-1:1] == own_addr);
    assign tout_run   = active && !scl_f && (state != ST_IDLE) && (state != ST_WAIT_STOP);

    i2c_bus_watch u_watch (
        .clk(clk), .rst_n(rst_n), .active(active), .scl_f(scl_f), .sda_f(sda_f),
        .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .busy(busy));

    i2c_tout_ctr #(.LIM_W(DW), .PRE_W(PRE_W)) u_tout (
        .clk(clk), .rst_n(rst_n), .run(tout_run), .limit(tout_lim), .expire(tout_ev));

    // next-state logic
    always_comb begin
        st_nx = state;
        if (!active || tout_ev || stop_ev) begin
            st_nx = ST_IDLE;
        end else if (start_ev) begin
            st_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT_STOP: st_nx = state;
                ST_ADDR:
                    if (scl_fall && bitcnt == BIT_FULL)
                        st_nx = addr_match ? ST_ADDR_ACK : ST_WAIT_STOP;
                ST_ADDR_ACK, ST_RX_ACK:
                    if (scl_fall) st_nx = ST_STRETCH;
                ST_STRETCH:
                    if (!hold_req) st_nx = rw_q ? ST_TX_BYTE : ST_RX_BYTE;
                ST_RX_BYTE:
                    if (scl_fall && bitcnt == BIT_FULL) st_nx = ST_RX_ACK;
                ST_TX_BYTE:
                    if (scl_fall && bitcnt == BIT_TXEND) st_nx = ST_TX_ACK;
                ST_TX_ACK:
                    if (scl_fall) st_nx = ack_sda ? ST_WAIT_STOP : ST_STRETCH;
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= st_nx;
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_mode <= '0; ctrl_en <= 1'b0; ctrl_irq_en <= 1'b0;
            own_addr  <= '0; tout_lim <= '0; tx_buf <= '0; rx_data <= '0;
            shreg     <= '0; bitcnt <= '0; rw_q <= 1'b0; addr_hit <= 1'b0;
            tout_flag <= 1'b0; irq_pend <= 1'b0; rx_nak <= 1'b0;
            hold_req  <= 1'b0; ack_sda <= 1'b1;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    SEL_CTRL: begin
                        ctrl_mode   <= reg_wdata[2:0];
                        ctrl_en     <= reg_wdata[3];
                        ctrl_irq_en <= reg_wdata[4];
                    end
                    SEL_STAT: begin
                        if (reg_wdata[ST_BIT_IRQ])  irq_pend  <= 1'b0;
                        if (reg_wdata[ST_BIT_TOUT]) tout_flag <= 1'b0;
                        if (reg_wdata[ST_BIT_NAK])  rx_nak    <= 1'b0;
                    end
                    SEL_OWN:  if (!ctrl_en) own_addr <= reg_wdata[AW-1:0];
                    SEL_DATA: tx_buf   <= reg_wdata;
                    SEL_TOUT: tout_lim <= reg_wdata;
                    default: ;
                endcase
            end
            if (hold_req && (rw_q ? data_wr : data_rd)) hold_req <= 1'b0;

            if (!active || stop_ev) begin
                addr_hit <= 1'b0;
                hold_req <= 1'b0;
            end else if (tout_ev) begin
                addr_hit  <= 1'b0;
                hold_req  <= 1'b0;
                tout_flag <= 1'b1;
                irq_pend  <= 1'b1;
            end else if (start_ev) begin
                addr_hit <= 1'b0;
                hold_req <= 1'b0;
                rx_nak   <= 1'b0;
                bitcnt   <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_RX_BYTE: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DW-2:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (scl_fall && bitcnt == BIT_FULL) begin
                            if (state == ST_RX_BYTE) begin
                                rx_data  <= shreg;
                                irq_pend <= 1'b1;
                                hold_req <= 1'b1;
                            end else if (addr_match) begin
                                addr_hit <= 1'b1;
                                rw_q     <= shreg[0];
                                irq_pend <= 1'b1;
                                hold_req <= 1'b1;
                            end
                        end
                    end
                    ST_STRETCH:
                        if (!hold_req) begin
                            bitcnt <= '0;
                            if (rw_q) shreg <= tx_buf;
                        end
                    ST_TX_BYTE:
                        if (scl_fall) begin
                            shreg  <= {shreg[DW-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    ST_TX_ACK: begin
                        if (scl_rise) ack_sda <= sda_f;
                        if (scl_fall) begin
                            irq_pend <= 1'b1;
                            if (ack_sda) rx_nak   <= 1'b1;
                            else         hold_req <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_STRETCH:             scl_oe = 1'b1;
            ST_ADDR_ACK, ST_RX_ACK: sda_oe = 1'b1;
            ST_TX_BYTE:             sda_oe = !shreg[DW-1];
            default: ;
        endcase
        irq = irq_pend && ctrl_irq_en;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL: reg_rdata = DW'({ctrl_irq_en, ctrl_en, ctrl_mode});
            SEL_STAT: reg_rdata = DW'({rx_nak, irq_pend, tout_flag, rw_q, addr_hit, busy});
            SEL_OWN:  reg_rdata = DW'(own_addr);
            SEL_DATA: reg_rdata = rx_data;
            SEL_TOUT: reg_rdata = tout_lim;
            default:  reg_rdata = '0;
        endcase
    end

    assert_ack_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> addr_hit);
    assert_hold_release_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_req) |-> $past(data_wr || data_rd || start_ev || stop_ev || tout_ev || !active));
    assert_own_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_en) |-> $stable(own_addr));
    assert_tout_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tout_ev |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/test_i2c_target_port.sv
module test_i2c_target_port;
    localparam int H = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_sel = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_bus, sda_bus;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_target_port i_i2c_target_port (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_i(scl_bus), .scl_oe(scl_oe), .sda_i(sda_bus), .sda_oe(sda_oe));

    function automatic bit exp_ack(input logic [6:0] a, input logic [6:0] own);
        return a == own;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic reg_peek(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk); reg_sel = s; #1 d = reg_rdata;
    endtask

    task automatic configure(input logic [6:0] own);
        reg_write(3'd0, 8'h00);
        reg_write(3'd2, {1'b0, own});
        reg_write(3'd0, 8'h1E);
    endtask

    task automatic wait_high;
        @(negedge clk);
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; wclk(H); scl_m = 1'b1; wait_high; wclk(H);
        sda_m = 1'b0; wclk(H); scl_m = 1'b0; wclk(H);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; wclk(H); scl_m = 1'b1; wait_high; wclk(H);
        sda_m = 1'b1; wclk(H);
    endtask

    task automatic m_bit_out(input logic b);
        sda_m = b; wclk(H); scl_m = 1'b1; wait_high; wclk(H); scl_m = 1'b0; wclk(H);
    endtask

    task automatic m_bit_in(output logic b);
        sda_m = 1'b1; wclk(H); scl_m = 1'b1; wait_high; wclk(H / 2);
        b = sda_bus; wclk(H / 2); scl_m = 1'b0; wclk(H);
    endtask

    task automatic m_send(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_bit_out(v[i]);
        m_bit_in(b);
        ack = !b;
    endtask

    task automatic m_recv(output logic [7:0] v, input logic nak);
        logic b;
        for (int i = 7; i >= 0; i--) begin m_bit_in(b); v[i] = b; end
        m_bit_out(nak);
    endtask

    initial begin
        logic [7:0] d, rx;
        logic       ack;
        logic [6:0] own, adr;
        logic       rw;
        void'($urandom(32'd1234));

        wclk(5); rst_n = 1'b1; wclk(5);
        reg_peek(3'd1, d); check("R1 reset status", d, 8'h00);
        check("R5 irq idle", irq, 0);

        // R7: own address locked while enabled
        configure(7'h3A);
        reg_write(3'd2, 8'h11);
        reg_peek(3'd2, d); check("R7 own locked", d, 8'h3A);

        // receive path: R1 R3 R4 R5 R6 R11 R2
        m_start;
        reg_peek(3'd1, d); check("R1 busy on start", d[0], 1);
        m_send({7'h3A, 1'b0}, ack); check("R3 ack match", ack, 1);
        check("R5 irq on match", irq, 1);
        reg_peek(3'd1, d); check("R5 hit flag", d[1], 1); check("R4 dir write", d[2], 0);
        reg_write(3'd1, 8'h10);
        fork
            m_send(8'hC5, ack);
            begin
                wclk(30); check("R6 scl stretched", scl_bus, 0);
                reg_read(3'd3, d);
            end
        join
        check("R11 data ack", ack, 1);
        check("R11 held until read", scl_oe, 1);
        check("R5 irq on byte", irq, 1);
        reg_read(3'd3, d); check("R11 rx data", d, 8'hC5);
        m_stop;
        reg_peek(3'd1, d); check("R2 busy cleared", d[0], 0); check("R2 hit cleared", d[1], 0);
        reg_write(3'd1, 8'h38);

        // transmit path: R4 R9 R10
        m_start;
        m_send({7'h3A, 1'b1}, ack); check("R3 ack read", ack, 1);
        reg_peek(3'd1, d); check("R4 dir read", d[2], 1);
        fork
            m_recv(rx, 1'b0);
            begin
                wclk(30); check("R6 tx stretch", scl_bus, 0);
                reg_write(3'd3, 8'h96);
            end
        join
        check("R9 tx byte msb", rx, 8'h96);
        check("R9 stretched after ack", scl_oe, 1);
        fork
            m_recv(rx, 1'b1);
            begin wclk(10); reg_write(3'd3, 8'h3C); end
        join
        check("R9 second byte", rx, 8'h3C);
        wclk(10);
        check("R10 sda released", sda_oe, 0);
        reg_peek(3'd1, d); check("R10 nak flag", d[5], 1);
        m_stop;
        reg_write(3'd1, 8'h38);

        // mismatch then repeated start: R3 R12
        m_start;
        m_send({7'h3B, 1'b0}, ack); check("R3 no ack mismatch", ack, 0);
        reg_peek(3'd1, d); check("R3 no hit", d[1], 0);
        check("R3 no irq", irq, 0);
        m_start;
        m_send({7'h3A, 1'b0}, ack); check("R12 ack after restart", ack, 1);
        reg_read(3'd3, d);
        m_stop;
        reg_write(3'd1, 8'h38);

        // wrong mode: R7
        reg_write(3'd0, 8'h18);
        m_start;
        reg_peek(3'd1, d); check("R7 no busy wrong mode", d[0], 0);
        m_send({7'h3A, 1'b0}, ack); check("R7 no ack wrong mode", ack, 0);
        m_stop;
        reg_write(3'd0, 8'h1E);

        // time-out: R8
        reg_write(3'd4, 8'd4);
        m_start;
        m_send({7'h3A, 1'b0}, ack); check("R8 setup ack", ack, 1);
        reg_write(3'd1, 8'h10);
        wclk(150);
        reg_peek(3'd1, d); check("R8 timeout flag", d[3], 1);
        check("R8 irq", irq, 1);
        check("R8 scl released", scl_oe, 0);
        reg_write(3'd4, 8'd0);
        reg_write(3'd1, 8'h38);
        m_stop;
        reg_peek(3'd1, d); check("R2 busy after tout stop", d[0], 0);

        // random transfers
        for (int it = 0; it < 16; it++) begin
            own = 7'($urandom);
            adr = ($urandom % 2) ? own : 7'($urandom);
            rw  = 1'($urandom);
            d   = 8'($urandom);
            configure(own);
            m_start;
            m_send({adr, rw}, ack);
            check("R3 random ack", ack, exp_ack(adr, own));
            if (exp_ack(adr, own)) begin
                reg_peek(3'd1, rx); check("R4 random dir", rx[2], rw);
                if (!rw) begin
                    fork
                        m_send(d, ack);
                        begin wclk(30); check("R6 random stretch", scl_bus, 0); reg_read(3'd3, rx); end
                    join
                    reg_read(3'd3, rx); check("R11 random rx", rx, d);
                end else begin
                    fork
                        m_recv(rx, 1'b1);
                        begin wclk(30); check("R6 random stretch", scl_bus, 0); reg_write(3'd3, d); end
                    join
                    check("R9 random tx", rx, d);
                    wclk(10); check("R10 random release", sda_oe, 0);
                end
            end
            m_stop;
            reg_write(3'd1, 8'h38);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule